// File: doc/BRIEF.md
# Eight-channel timer control register bank

This block is the 32-bit memory-mapped front end of a bank of timer channels. A single-cycle bus access (select, write flag, byte address, write data) is decoded either onto one channel's four registers or onto a shared group of control registers. A channel write raises that channel's strobe and carries the register index and the data. A channel read returns the word that the selected channel presents. The counters themselves sit outside this block.

The control word packs one nibble per channel: an enable, a clock-source select, a zero-reached interrupt enable and a pulse-output enable. A control update is applied in a fixed order. Enables that drop take effect on the write edge. The three configuration bits follow one cycle later. Enables that rise take effect one cycle after that, so a channel never runs while its configuration is changing. A second control register only stores a value. A command register holds a lock. While that lock is open, a clear alias resets the selected control bits, and the result goes through the same ordered sequence.

Top module: `tmr_regbank`

## Requirements
- R1: After reset all control outputs are 0. Reads of the control word (0x30), the second control register (0x34) and the lock register (0x38) return 0.
- R2: A write to a channel window raises only that channel's bit of `chan_wr_stb`, in the same cycle. `chan_reg_idx` is address bits 3:2 (0 count, 1 reload, 2 first match, 3 second match) and `chan_wdata` is the write data. Channel c (0-based) has its window at c*0x10 for c<3 and at (c+1)*0x10 for c>=3. Window 0x30 is the control group.
- R3: A read of a channel window returns that channel's `chan_rdata` word in the same cycle.
- R4: The control word holds channel c in bits 4c+3:4c. Bit 0 of the nibble is enable, bit 1 is clock select, bit 2 is zero interrupt enable and bit 3 is pulse enable. Reading 0x30 returns the word currently driven on the control outputs.
- R5: A control update that takes effect at edge t clears the dropping enables at t. It applies the configuration bits at t+1 and sets the rising enables at t+2. Configuration and enable bits never change on the same edge.
- R6: A control update that arrives while an earlier one is still in progress replaces it and restarts the sequence from the current outputs.
- R7: A write to 0x34 stores the data, which reads back from 0x34 and has no effect on the control outputs.
- R8: A write to 0x38 takes write-data bits 8:1 as a command: 0xAE opens the lock, 0xEA closes it, and any other value leaves it unchanged. Reading 0x38 returns the lock state in bit 0 and zero in bits 31:1.
- R9: A write to 0x3C while the lock is open clears every control bit whose write-data bit is 1, through the R5 sequence. While the lock is closed the write has no effect. Reading 0x3C returns 0.
- R10: Pulse enable bits of channels 0 to 3 are never set. A control write that asks for one of them raises `pulse_err` in that cycle.
- R11: An access to an unmapped offset, or to an address with bits 1:0 nonzero, reads 0, changes nothing and raises `acc_err` in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| acc_err | output | 1 | Unmapped or misaligned access strobe |
| pulse_err | output | 1 | Pulse requested on a channel without pulse support |
| chan_wr_stb | output | 8 | Per-channel register write strobe |
| chan_reg_idx | output | 2 | Register index within the channel window |
| chan_wdata | output | 32 | Channel write data |
| chan_rdata | input | 256 | Channel read words, channel c at bits 32c+31:32c |
| ctl_en | output | 8 | Per-channel enable |
| ctl_extclk | output | 8 | Per-channel clock select |
| ctl_zint | output | 8 | Per-channel zero interrupt enable |
| ctl_pulse | output | 8 | Per-channel pulse enable |

## Verification
Several properties are checked on every cycle. Configuration bits and enables never move on the same edge. The low channels' pulse bits stay clear. The lock opens only after the open command. At most one channel strobe is active, and never together with an access error. Other behaviours can only be shown by the bench's scenarios against its cycle model: the exact two-cycle spacing between a dropping and a rising enable, replacement of an update in flight, clearing through the alias while the lock is open and closed, and the read mux.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int NIB       = 4;
   localparam int B_EN      = 0;
   localparam int B_PULSE   = 3;

   typedef enum logic [2:0] {
      K_CHAN, K_CTL, K_CTL2, K_LOCK, K_CLR, K_BAD
   } kind_t;

   typedef enum logic [1:0] {
      SQ_IDLE, SQ_CFG, SQ_EN
   } seq_t;

   // bit 'pos' of every nibble for channels first..last-1
   function automatic logic [31:0] nib_mask(int pos, int first, int last);
      logic [31:0] m;
      m = '0;
      for (int c = first; c < last; c++) m[c*NIB + pos] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec
   import tmr_pkg::*;
#(
   parameter int NCHAN  = 8,
   parameter int ADDR_W = 8,
   localparam int CHW   = $clog2(NCHAN)
) (
   input  logic [ADDR_W-1:0] addr,
   output kind_t             kind,
   output logic [CHW-1:0]    chan,
   output logic [1:0]        reg_idx
);
   localparam logic [3:0] CTL_WIN = 4'd3;

   logic [3:0] win;
   logic [3:0] chn;

   always_comb begin
      win     = addr[7:4];
      chn     = (win > CTL_WIN) ? win - 4'd1 : win;
      chan    = chn[CHW-1:0];
      reg_idx = addr[3:2];
      if (addr[1:0] != 2'b00 || (addr >> 8) != '0) begin
         kind = K_BAD;
      end else if (win == CTL_WIN) begin
         case (addr[3:2])
            2'd0:    kind = K_CTL;
            2'd1:    kind = K_CTL2;
            2'd2:    kind = K_LOCK;
            default: kind = K_CLR;
         endcase
      end else if (int'(chn) < NCHAN) begin
         kind = K_CHAN;
      end else begin
         kind = K_BAD;
      end
   end
endmodule

// File: rtl/tmr_lock.sv
module tmr_lock #(
   parameter logic [7:0] KEY_OPEN = 8'hAE,
   parameter logic [7:0] KEY_SHUT = 8'hEA
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_wr,
   input  logic [7:0] cmd,
   output logic       unlocked
);
   logic open_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                         open_q <= 1'b0;
      else if (cmd_wr && cmd == KEY_OPEN) open_q <= 1'b1;
      else if (cmd_wr && cmd == KEY_SHUT) open_q <= 1'b0;
   end

   assign unlocked = open_q;

   // R8: the lock opens only after the open command
   assert_open_by_key_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(open_q) |-> $past(cmd_wr && cmd == KEY_OPEN));
endmodule

// File: rtl/tmr_ctl_seq.sv
module tmr_ctl_seq
   import tmr_pkg::*;
#(
   parameter int NCHAN       = 8,
   parameter int PULSE_FIRST = 4,
   localparam int CW         = NCHAN * NIB
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_word,
   output logic [CW-1:0] word
);
   localparam logic [31:0] ENM32  = nib_mask(B_EN, 0, NCHAN);
   localparam logic [31:0] LOWP32 = nib_mask(B_PULSE, 0, PULSE_FIRST);
   localparam logic [CW-1:0] ENM  = ENM32[CW-1:0];
   localparam logic [CW-1:0] LOWP = LOWP32[CW-1:0];

   seq_t          st_q;
   logic [CW-1:0] word_q;
   logic [CW-1:0] tgt_q;
   logic [CW-1:0] next_tgt;

   assign next_tgt = load_word & ~LOWP;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= SQ_IDLE;
         word_q <= '0;
         tgt_q  <= '0;
      end else if (load) begin
         word_q <= word_q & (next_tgt | ~ENM);
         tgt_q  <= next_tgt;
         st_q   <= SQ_CFG;
      end else if (st_q == SQ_CFG) begin
         word_q <= (word_q & ENM) | (tgt_q & ~ENM);
         st_q   <= SQ_EN;
      end else if (st_q == SQ_EN) begin
         word_q <= tgt_q;
         st_q   <= SQ_IDLE;
      end
   end

   assign word = word_q;

   // R5: configuration and enables never move on the same edge
   assert_cfg_en_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(word_q & ~ENM) |-> $stable(word_q & ENM));
   // R5: an enable rises only two edges after an update was taken
   assert_rise_late_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((word_q & ENM & ~$past(word_q)) != '0) |-> $past(st_q == SQ_EN));
   // R10: low channels never hold a pulse bit
   assert_low_pulse_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (word_q & LOWP) == '0);
endmodule

// File: rtl/tmr_regbank.sv
module tmr_regbank
   import tmr_pkg::*;
#(
   parameter int NCHAN       = 8,
   parameter int PULSE_FIRST = 4,
   parameter int ADDR_W      = 8,
   parameter int DW          = 32,
   localparam int CW         = NCHAN * NIB,
   localparam int CHW        = $clog2(NCHAN)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_sel,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DW-1:0]       bus_wdata,
   output logic [DW-1:0]       bus_rdata,
   output logic                acc_err,
   output logic                pulse_err,
   output logic [NCHAN-1:0]    chan_wr_stb,
   output logic [1:0]          chan_reg_idx,
   output logic [DW-1:0]       chan_wdata,
   input  logic [NCHAN*DW-1:0] chan_rdata,
   output logic [NCHAN-1:0]    ctl_en,
   output logic [NCHAN-1:0]    ctl_extclk,
   output logic [NCHAN-1:0]    ctl_zint,
   output logic [NCHAN-1:0]    ctl_pulse
);
   if (NCHAN < 4 || NCHAN > 8) begin : g_bad_nchan
      $error("NCHAN must lie in 4..8");
   end
   if (PULSE_FIRST < 0 || PULSE_FIRST > NCHAN) begin : g_bad_pulse
      $error("PULSE_FIRST out of range");
   end
   if (ADDR_W < 8 || DW != 32) begin : g_bad_bus
      $error("bus needs ADDR_W >= 8 and DW == 32");
   end

   localparam logic [31:0]   LOWP32 = nib_mask(B_PULSE, 0, PULSE_FIRST);
   localparam logic [CW-1:0] LOWP   = LOWP32[CW-1:0];

   kind_t          kind;
   logic [CHW-1:0] chan;
   logic [CW-1:0]  word;
   logic [DW-1:0]  ctl2_q;
   logic           unlocked;
   logic           wr_ctl, wr_clr, do_load;
   logic [CW-1:0]  load_word;

   tmr_addr_dec #(.NCHAN(NCHAN), .ADDR_W(ADDR_W)) u_dec (
      .addr(bus_addr), .kind(kind), .chan(chan), .reg_idx(chan_reg_idx));

   tmr_lock u_lock (
      .clk(clk), .rst_n(rst_n),
      .cmd_wr(bus_sel && bus_wr && kind == K_LOCK),
      .cmd(bus_wdata[8:1]), .unlocked(unlocked));

   assign wr_ctl    = bus_sel && bus_wr && kind == K_CTL;
   assign wr_clr    = bus_sel && bus_wr && kind == K_CLR && unlocked;
   assign do_load   = wr_ctl || wr_clr;
   assign load_word = wr_ctl ? bus_wdata[CW-1:0] : (word & ~bus_wdata[CW-1:0]);

   tmr_ctl_seq #(.NCHAN(NCHAN), .PULSE_FIRST(PULSE_FIRST)) u_seq (
      .clk(clk), .rst_n(rst_n), .load(do_load), .load_word(load_word), .word(word));

   always_ff @(posedge clk) begin
      if (!rst_n)                                  ctl2_q <= '0;
      else if (bus_sel && bus_wr && kind == K_CTL2) ctl2_q <= bus_wdata;
   end

   for (genvar c = 0; c < NCHAN; c++) begin : g_chan
      assign chan_wr_stb[c] = bus_sel && bus_wr && kind == K_CHAN && int'(chan) == c;
      assign ctl_en[c]      = word[c*NIB + 0];
      assign ctl_extclk[c]  = word[c*NIB + 1];
      assign ctl_zint[c]    = word[c*NIB + 2];
      assign ctl_pulse[c]   = word[c*NIB + 3];
   end

   assign chan_wdata = bus_wdata;
   assign acc_err    = bus_sel && kind == K_BAD;
   assign pulse_err  = wr_ctl && ((bus_wdata[CW-1:0] & LOWP) != '0);

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         case (kind)
            K_CHAN:  bus_rdata = chan_rdata[int'(chan)*DW +: DW];
            K_CTL:   bus_rdata = DW'(word);
            K_CTL2:  bus_rdata = ctl2_q;
            K_LOCK:  bus_rdata = DW'(unlocked);
            default: bus_rdata = '0;
         endcase
      end
   end

   // R2: at most one channel strobe, and only on a write
   assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(chan_wr_stb) && ((chan_wr_stb == '0) || bus_wr));
   // R11: a bad access never reaches a channel
   assert_bad_no_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
      acc_err |-> chan_wr_stb == '0);
   // R9: a clear while locked leaves the outputs alone on the next edge
   assert_locked_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && kind == K_CLR && !unlocked && !wr_ctl &&
       u_seq.st_q == SQ_IDLE) |=> $stable(word));
endmodule

// File: tb/sim_tmr_regbank.sv
`timescale 1ns/1ps
module sim_tmr_regbank;
   localparam int N = 8;

   logic clk = 0, rst_n = 0;
   logic bus_sel = 0, bus_wr = 0;
   logic [7:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic acc_err, pulse_err;
   logic [N-1:0] chan_wr_stb, ctl_en, ctl_extclk, ctl_zint, ctl_pulse;
   logic [1:0] chan_reg_idx;
   logic [31:0] chan_wdata;
   logic [N*32-1:0] chan_rdata;

   int checks = 0, errors = 0, cyc = 0;
   bit done = 0;

   always #2 clk = ~clk;

   always_comb
      for (int c = 0; c < N; c++)
         chan_rdata[c*32 +: 32] = {16'hA5A5, 8'(c), 6'd0, chan_reg_idx};

   tmr_regbank u0 (.*);

   // reference state
   logic [31:0] m_ctrl = 0, m_tgt = 0, m_ctl2 = 0;
   int m_step = 0;
   bit m_open = 0;
   localparam logic [31:0] ENM  = 32'h1111_1111;
   localparam logic [31:0] LOWP = 32'h0000_8888;

   always @(posedge clk) begin
      logic [31:0] t;
      bit is_ctl, is_clr;
      if (!rst_n) begin
         m_ctrl = 0; m_tgt = 0; m_ctl2 = 0; m_step = 0; m_open = 0;
      end else begin
         is_ctl = bus_sel && bus_wr && bus_addr == 8'h30;
         is_clr = bus_sel && bus_wr && bus_addr == 8'h3C && m_open;
         if (is_ctl || is_clr) begin
            t = is_ctl ? bus_wdata : (m_ctrl & ~bus_wdata);
            t = t & ~LOWP;
            m_ctrl = m_ctrl & (t | ~ENM);
            m_tgt = t; m_step = 1;
         end else if (m_step == 1) begin
            m_ctrl = (m_ctrl & ENM) | (m_tgt & ~ENM); m_step = 2;
         end else if (m_step == 2) begin
            m_ctrl = m_tgt; m_step = 0;
         end
         if (bus_sel && bus_wr && bus_addr == 8'h34) m_ctl2 = bus_wdata;
         if (bus_sel && bus_wr && bus_addr == 8'h38) begin
            if (bus_wdata[8:1] == 8'hAE) m_open = 1;
            else if (bus_wdata[8:1] == 8'hEA) m_open = 0;
         end
      end
   end

   function automatic logic [31:0] dut_word();
      logic [31:0] w = 0;
      for (int c = 0; c < N; c++)
         w[c*4 +: 4] = {ctl_pulse[c], ctl_zint[c], ctl_extclk[c], ctl_en[c]};
      return w;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // per-cycle comparison of the control outputs (R4, R5, R6)
   always @(negedge clk) if (rst_n) chk("R5 cycle", dut_word(), m_ctrl);

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      #1;
   endtask

   task automatic idle();
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd(logic [7:0] a, logic [31:0] exp, string req);
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      #1 chk(req, bus_rdata, exp);
   endtask

   task automatic settle();
      idle(); repeat (3) @(negedge clk);
   endtask

   function automatic logic [31:0] cw(int c, int r);
      return {16'hA5A5, 8'(c), 8'(r)};
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected <20000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1
      #1 chk("R1 outputs", dut_word(), 0);
      rd(8'h30, 0, "R1 ctl"); rd(8'h34, 0, "R1 ctl2"); rd(8'h38, 0, "R1 lock");
      // R2 channel writes
      wr(8'h14, 32'h1234_5678);
      chk("R2 stb ch1", 32'(chan_wr_stb), 32'h02); chk("R2 idx", 32'(chan_reg_idx), 1);
      chk("R2 data", chan_wdata, 32'h1234_5678);
      wr(8'h48, 32'h0);
      chk("R2 stb ch3", 32'(chan_wr_stb), 32'h08); chk("R2 idx m1", 32'(chan_reg_idx), 2);
      wr(8'h8C, 32'h1);
      chk("R2 stb ch7", 32'(chan_wr_stb), 32'h80);
      // R3 read mux
      rd(8'h28, cw(2, 2), "R3 ch2"); rd(8'h40, cw(3, 0), "R3 ch3");
      rd(8'h8C, cw(7, 3), "R3 ch7");
      // R4/R5 ordering
      wr(8'h30, 32'h0011_1111); settle();
      rd(8'h30, 32'h0011_1111, "R4 readback");
      wr(8'h30, 32'h0011_1116); idle();
      chk("R5 drop first", 32'(ctl_en[0]), 0); chk("R5 cfg waits", 32'(ctl_extclk[0]), 0);
      @(negedge clk); chk("R5 cfg next", 32'(ctl_zint[0]), 1);
      wr(8'h30, 32'h0011_1117); idle();
      chk("R5 cfg stays", 32'(ctl_en[0]), 0);
      @(negedge clk); chk("R5 en waits", 32'(ctl_en[0]), 0);
      @(negedge clk); chk("R5 en last", 32'(ctl_en[0]), 1);
      // R6 replacement in flight
      wr(8'h30, 32'h0000_0001); wr(8'h30, 32'h0000_0700); settle();
      rd(8'h30, 32'h0000_0700, "R6 replaced");
      // R10 pulse
      wr(8'h30, 32'h0008_8008);
      chk("R10 err", 32'(pulse_err), 1);
      settle(); rd(8'h30, 32'h0008_0000, "R10 masked");
      wr(8'h30, 32'h0080_0001); chk("R10 no err", 32'(pulse_err), 0); settle();
      // R7
      wr(8'h34, 32'hDEAD_BEEF); settle();
      rd(8'h34, 32'hDEAD_BEEF, "R7 ctl2"); rd(8'h30, 32'h0080_0001, "R7 no effect");
      // R9 locked clear, R8 commands
      wr(8'h3C, 32'hFFFF_FFFF); settle();
      rd(8'h30, 32'h0080_0001, "R9 locked ignored");
      wr(8'h38, 32'h55 << 1); idle(); rd(8'h38, 0, "R8 other cmd");
      wr(8'h38, 32'hAE << 1); idle(); rd(8'h38, 1, "R8 open");
      rd(8'h3C, 0, "R9 read zero"); chk("R9 no err", 32'(acc_err), 0);
      wr(8'h3C, 32'h0000_0001); settle();
      rd(8'h30, 32'h0080_0000, "R9 cleared");
      wr(8'h38, 32'hEA << 1); idle(); rd(8'h38, 0, "R8 shut");
      // R11
      wr(8'h90, 32'hFFFF_FFFF);
      chk("R11 err", 32'(acc_err), 1); chk("R11 no stb", 32'(chan_wr_stb), 0);
      rd(8'h90, 0, "R11 read"); chk("R11 rd err", 32'(acc_err), 1);
      wr(8'h31, 32'h0000_0011); chk("R11 misaligned", 32'(acc_err), 1);
      settle(); rd(8'h30, 32'h0080_0000, "R11 ignored");
      idle(); repeat (2) @(negedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule